// File: doc/BRIEF.md
# Memory-Reference Instruction Decoder

This block decodes the memory-reference group of a 12-bit word minicomputer in a single combinational step. From the instruction word, the address of the instruction being decoded (a 3-bit field above a 12-bit offset) and the packed data-field/instruction-field register, it produces the opcode class and the sequencing flags. The flags say whether an operand is fetched, whether a result is written back, whether the accumulator and link are read or written, and whether control flow may change.

It forms the 15-bit operand address. The address is page-zero or current-page, and the data field sits above it. The block marks the address as final or as an indirect pointer location. It requests an autoincrement write-back when a non-jump instruction points indirectly through one of the autoincrement slots. It also gives the sequential next PC. For a direct jump or subroutine call it gives the redirect target in the instruction field. The I/O and operate groups are only flagged as unsupported. A sequencer uses these outputs to schedule its memory cycles and execution.

Top module: `mri_decoder`

## Requirements
- R1: `opcode_o` equals instruction bits 11:9. The codes are: 0 logical AND, 1 two's-complement add, 2 increment-and-skip, 3 deposit-and-clear, 4 subroutine call, 5 jump, 6 I/O transfer, 7 operate.
- R2: `next_pc_o` keeps `pc_i[14:12]` and sets its low 12 bits to `pc_i[11:0]+1` modulo 4096.
- R3: For opcodes 0–5, `addr_o[6:0]` equals instruction bits 6:0. `addr_o[11:7]` equals `pc_i[11:7]` when instruction bit 7 is 1, and is zero when bit 7 is 0.
- R4: For opcodes 0–5, `addr_o[14:12]` equals `dfif_i[5:3]` (data field). `dfif_i[2:0]` is the instruction field.
- R5: For opcodes 0–5, `indirect_o` equals instruction bit 8. For opcodes 6 and 7 it is 0 whatever bit 8 holds.
- R6: Opcode 0 raises `load_o`, `acc_rd_o` and `acc_wr_o` only. Opcode 1 raises those plus `link_rd_o` and `link_wr_o`.
- R7: Opcode 2 raises `load_o`, `store_o` and `redirect_o` only. Opcode 3 raises `store_o`, `acc_rd_o` and `acc_wr_o` only.
- R8: Opcode 4 raises `store_o` and `redirect_o` only. Opcode 5 raises `redirect_o` only.
- R9: Opcodes 6 and 7 raise `unsupported_o`. Every other flag is 0 and `addr_o` is zero.
- R10: `autoinc_o` is 1 exactly when `indirect_o` is 1, `redirect_o` is 0 and instruction bits 6:3 equal 4'b0001. Bit 7 plays no part.
- R11: `jump_tgt_valid_o` is 1 only for direct opcodes 4 and 5. Opcode 5 gives `{dfif_i[2:0], addr_o[11:0]}`. Opcode 4 gives `{dfif_i[2:0], addr_o[11:0]+1 mod 4096}`. The target is zero when not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word |
| pc_i | input | 15 | Address of this instruction: field 14:12, offset 11:0 |
| dfif_i | input | 6 | Data field in 5:3, instruction field in 2:0 |
| opcode_o | output | 3 | Opcode class |
| load_o | output | 1 | Operand fetch needed |
| store_o | output | 1 | Operand write-back needed |
| acc_rd_o | output | 1 | Accumulator read |
| acc_wr_o | output | 1 | Accumulator written |
| link_rd_o | output | 1 | Link read |
| link_wr_o | output | 1 | Link written |
| redirect_o | output | 1 | Control flow may change |
| unsupported_o | output | 1 | I/O or operate group, not handled here |
| indirect_o | output | 1 | `addr_o` is a pointer location |
| addr_o | output | 15 | Operand or pointer address |
| autoinc_o | output | 1 | Pointer write-back with increment needed |
| next_pc_o | output | 15 | Sequential next PC |
| jump_tgt_valid_o | output | 1 | `jump_tgt_o` is final |
| jump_tgt_o | output | 15 | Redirect target of a direct jump or call |

## Verification
Every output is a pure function of the three inputs and holds no state, so each result is due in the same cycle as its stimulus. The bench drives inputs just after a rising clock edge and samples on the following falling edge, once the logic has settled. It never samples at an edge where inputs change. The table walk covers page selection, field placement, offset wrap and target wrap. The sweeps then cover every opcode and every value of the autoincrement bits.

// File: rtl/mri_pkg.sv
package mri_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_TAD = 3'd1,
    OP_ISZ = 3'd2,
    OP_DCA = 3'd3,
    OP_JMS = 3'd4,
    OP_JMP = 3'd5,
    OP_IOT = 3'd6,
    OP_OPR = 3'd7
  } op_e;

  typedef struct packed {
    logic load;
    logic store;
    logic acc_rd;
    logic acc_wr;
    logic link_rd;
    logic link_wr;
    logic redirect;
    logic unsup;
  } seq_flags_t;

endpackage

// File: rtl/mri_op_class.sv
module mri_op_class
  import mri_pkg::*;
(
  input  op_e        op_i,
  output seq_flags_t flags_o
);

  always_comb begin
    flags_o = '0;
    unique case (op_i)
      OP_AND: begin
        flags_o.load   = 1'b1;
        flags_o.acc_rd = 1'b1;
        flags_o.acc_wr = 1'b1;
      end
      OP_TAD: begin
        flags_o.load    = 1'b1;
        flags_o.acc_rd  = 1'b1;
        flags_o.acc_wr  = 1'b1;
        flags_o.link_rd = 1'b1;
        flags_o.link_wr = 1'b1;
      end
      OP_ISZ: begin
        flags_o.load     = 1'b1;
        flags_o.store    = 1'b1;
        flags_o.redirect = 1'b1;
      end
      OP_DCA: begin
        flags_o.store  = 1'b1;
        flags_o.acc_rd = 1'b1;
        flags_o.acc_wr = 1'b1;
      end
      OP_JMS: begin
        flags_o.store    = 1'b1;
        flags_o.redirect = 1'b1;
      end
      OP_JMP: flags_o.redirect = 1'b1;
      default: flags_o.unsup = 1'b1;
    endcase
  end

endmodule

// File: rtl/mri_ea_gen.sv
module mri_ea_gen #(
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int PAGE_OFS_W = 7
) (
  input  logic                        mem_ref_i,
  input  logic                        ind_bit_i,
  input  logic                        page_bit_i,
  input  logic [PAGE_OFS_W-1:0]       ofs_i,
  input  logic [WORD_W-PAGE_OFS_W-1:0] cur_page_i,
  input  logic [FIELD_W-1:0]          dfield_i,
  output logic [FIELD_W+WORD_W-1:0]   addr_o,
  output logic                        indirect_o
);

  localparam int PAGE_W = WORD_W - PAGE_OFS_W;

  logic [PAGE_W-1:0] page_sel;

  assign page_sel   = page_bit_i ? cur_page_i : '0;
  assign addr_o     = mem_ref_i ? {dfield_i, page_sel, ofs_i} : '0;
  assign indirect_o = mem_ref_i & ind_bit_i;

endmodule

// File: rtl/mri_autoinc.sv
module mri_autoinc #(
  parameter int PAGE_OFS_W = 7,
  parameter int SLOT_LSB   = 3
) (
  input  logic                           indirect_i,
  input  logic                           redirect_i,
  input  logic [PAGE_OFS_W-1:SLOT_LSB]   slot_bits_i,
  output logic                           autoinc_o
);

  localparam int SLOT_W = PAGE_OFS_W - SLOT_LSB;
  localparam logic [SLOT_W-1:0] SLOT_MATCH = SLOT_W'(1);

  assign autoinc_o = indirect_i & ~redirect_i & (slot_bits_i == SLOT_MATCH);

endmodule

// File: rtl/mri_jump_tgt.sv
module mri_jump_tgt
  import mri_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input  op_e                        op_i,
  input  logic                       indirect_i,
  input  logic [WORD_W-1:0]          ofs_i,
  input  logic [FIELD_W-1:0]         ifield_i,
  output logic                       valid_o,
  output logic [FIELD_W+WORD_W-1:0]  tgt_o
);

  logic [WORD_W-1:0] ofs_inc;

  assign ofs_inc = ofs_i + WORD_W'(1);

  always_comb begin
    valid_o = 1'b0;
    tgt_o   = '0;
    if (!indirect_i) begin
      if (op_i == OP_JMP) begin
        valid_o = 1'b1;
        tgt_o   = {ifield_i, ofs_i};
      end else if (op_i == OP_JMS) begin
        // subroutine entry skips the return-address slot
        valid_o = 1'b1;
        tgt_o   = {ifield_i, ofs_inc};
      end
    end
  end

endmodule

// File: rtl/mri_decoder.sv
module mri_decoder
  import mri_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int PAGE_OFS_W = 7
) (
  input  logic [WORD_W-1:0]          instr_i,
  input  logic [FIELD_W+WORD_W-1:0]  pc_i,
  input  logic [2*FIELD_W-1:0]       dfif_i,
  output logic [2:0]                 opcode_o,
  output logic                       load_o,
  output logic                       store_o,
  output logic                       acc_rd_o,
  output logic                       acc_wr_o,
  output logic                       link_rd_o,
  output logic                       link_wr_o,
  output logic                       redirect_o,
  output logic                       unsupported_o,
  output logic                       indirect_o,
  output logic [FIELD_W+WORD_W-1:0]  addr_o,
  output logic                       autoinc_o,
  output logic [FIELD_W+WORD_W-1:0]  next_pc_o,
  output logic                       jump_tgt_valid_o,
  output logic [FIELD_W+WORD_W-1:0]  jump_tgt_o
);

  localparam int ADDR_W   = FIELD_W + WORD_W;
  localparam int IND_BIT  = PAGE_OFS_W + 1;
  localparam int PAGE_BIT = PAGE_OFS_W;

  op_e        op;
  seq_flags_t flags;
  logic       mem_ref;

  assign op = op_e'(instr_i[WORD_W-1 -: 3]);

  mri_op_class u_op_class (
    .op_i    (op),
    .flags_o (flags)
  );

  assign mem_ref = flags.load | flags.store | flags.redirect;

  mri_ea_gen #(
    .WORD_W     (WORD_W),
    .FIELD_W    (FIELD_W),
    .PAGE_OFS_W (PAGE_OFS_W)
  ) u_ea_gen (
    .mem_ref_i  (mem_ref),
    .ind_bit_i  (instr_i[IND_BIT]),
    .page_bit_i (instr_i[PAGE_BIT]),
    .ofs_i      (instr_i[PAGE_OFS_W-1:0]),
    .cur_page_i (pc_i[WORD_W-1:PAGE_OFS_W]),
    .dfield_i   (dfif_i[2*FIELD_W-1:FIELD_W]),
    .addr_o     (addr_o),
    .indirect_o (indirect_o)
  );

  mri_autoinc #(
    .PAGE_OFS_W (PAGE_OFS_W),
    .SLOT_LSB   (3)
  ) u_autoinc (
    .indirect_i  (indirect_o),
    .redirect_i  (flags.redirect),
    .slot_bits_i (instr_i[PAGE_OFS_W-1:3]),
    .autoinc_o   (autoinc_o)
  );

  mri_jump_tgt #(
    .WORD_W  (WORD_W),
    .FIELD_W (FIELD_W)
  ) u_jump_tgt (
    .op_i       (op),
    .indirect_i (indirect_o),
    .ofs_i      (addr_o[WORD_W-1:0]),
    .ifield_i   (dfif_i[FIELD_W-1:0]),
    .valid_o    (jump_tgt_valid_o),
    .tgt_o      (jump_tgt_o)
  );

  // field bits ride through, offset wraps within the field
  assign next_pc_o = {pc_i[ADDR_W-1:WORD_W], pc_i[WORD_W-1:0] + WORD_W'(1)};

  assign opcode_o      = instr_i[WORD_W-1 -: 3];
  assign load_o        = flags.load;
  assign store_o       = flags.store;
  assign acc_rd_o      = flags.acc_rd;
  assign acc_wr_o      = flags.acc_wr;
  assign link_rd_o     = flags.link_rd;
  assign link_wr_o     = flags.link_wr;
  assign redirect_o    = flags.redirect;
  assign unsupported_o = flags.unsup;

endmodule

// File: rtl/mri_decoder_chk.sv
module mri_decoder_chk #(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input logic [WORD_W-1:0]         instr_i,
  input logic [FIELD_W+WORD_W-1:0] pc_i,
  input logic [2*FIELD_W-1:0]      dfif_i,
  input logic                      load_o,
  input logic                      store_o,
  input logic                      acc_rd_o,
  input logic                      acc_wr_o,
  input logic                      link_wr_o,
  input logic                      redirect_o,
  input logic                      unsupported_o,
  input logic                      indirect_o,
  input logic [FIELD_W+WORD_W-1:0] addr_o,
  input logic                      autoinc_o,
  input logic [FIELD_W+WORD_W-1:0] next_pc_o,
  input logic                      jump_tgt_valid_o
);

  always_comb begin
    assert_field_kept_R2: assert (next_pc_o[FIELD_W+WORD_W-1:WORD_W] == pc_i[FIELD_W+WORD_W-1:WORD_W]);
    if (load_o || store_o || redirect_o) begin
      assert_dfield_placed_R4: assert (addr_o[FIELD_W+WORD_W-1:WORD_W] == dfif_i[2*FIELD_W-1:FIELD_W]);
      assert_low_ofs_R3: assert (addr_o[6:0] == instr_i[6:0]);
    end
    if (indirect_o) begin
      assert_ind_needs_mem_R5: assert (load_o || store_o || redirect_o);
    end
    if (link_wr_o) begin
      assert_link_acc_R6: assert (acc_wr_o && acc_rd_o && load_o);
    end
    if (unsupported_o) begin
      assert_quiet_unsup_R9: assert (!load_o && !store_o && !redirect_o && !acc_wr_o
                                     && !indirect_o && addr_o == '0);
    end
    if (autoinc_o) begin
      assert_autoinc_cond_R10: assert (indirect_o && !redirect_o);
    end
    if (jump_tgt_valid_o) begin
      assert_tgt_direct_R11: assert (redirect_o && !indirect_o && !load_o);
    end
  end

endmodule

bind mri_decoder mri_decoder_chk #(
  .WORD_W  (WORD_W),
  .FIELD_W (FIELD_W)
) u_chk (
  .instr_i          (instr_i),
  .pc_i             (pc_i),
  .dfif_i           (dfif_i),
  .load_o           (load_o),
  .store_o          (store_o),
  .acc_rd_o         (acc_rd_o),
  .acc_wr_o         (acc_wr_o),
  .link_wr_o        (link_wr_o),
  .redirect_o       (redirect_o),
  .unsupported_o    (unsupported_o),
  .indirect_o       (indirect_o),
  .addr_o           (addr_o),
  .autoinc_o        (autoinc_o),
  .next_pc_o        (next_pc_o),
  .jump_tgt_valid_o (jump_tgt_valid_o)
);

// File: tb/mri_decoder_tb_top.sv
`timescale 1ns/1ps
module mri_decoder_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] instr_i;
  logic [14:0] pc_i;
  logic [5:0]  dfif_i;
  logic [2:0]  opcode_o;
  logic load_o, store_o, acc_rd_o, acc_wr_o, link_rd_o, link_wr_o;
  logic redirect_o, unsupported_o, indirect_o, autoinc_o, jump_tgt_valid_o;
  logic [14:0] addr_o, next_pc_o, jump_tgt_o;

  mri_decoder dut_i (
    .instr_i          (instr_i),
    .pc_i             (pc_i),
    .dfif_i           (dfif_i),
    .opcode_o         (opcode_o),
    .load_o           (load_o),
    .store_o          (store_o),
    .acc_rd_o         (acc_rd_o),
    .acc_wr_o         (acc_wr_o),
    .link_rd_o        (link_rd_o),
    .link_wr_o        (link_wr_o),
    .redirect_o       (redirect_o),
    .unsupported_o    (unsupported_o),
    .indirect_o       (indirect_o),
    .addr_o           (addr_o),
    .autoinc_o        (autoinc_o),
    .next_pc_o        (next_pc_o),
    .jump_tgt_valid_o (jump_tgt_valid_o),
    .jump_tgt_o       (jump_tgt_o)
  );

  typedef struct packed {
    logic [11:0] instr;
    logic [14:0] pc;
    logic [5:0]  dfif;
    logic [14:0] addr;
    logic        ind;
    logic        ainc;
    logic [14:0] npc;
    logic        tv;
    logic [14:0] tgt;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{12'o0000, 15'o00200, 6'o00, 15'o00000, 1'b0, 1'b0, 15'o00201, 1'b0, 15'o00000},
    '{12'o1345, 15'o12345, 6'o52, 15'o52345, 1'b0, 1'b0, 15'o12346, 1'b0, 15'o00000},
    '{12'o2410, 15'o30777, 6'o70, 15'o70010, 1'b1, 1'b0, 15'o31000, 1'b0, 15'o00000},
    '{12'o0417, 15'o07777, 6'o30, 15'o30017, 1'b1, 1'b1, 15'o00000, 1'b0, 15'o00000},
    '{12'o1420, 15'o00100, 6'o07, 15'o00020, 1'b1, 1'b0, 15'o00101, 1'b0, 15'o00000},
    '{12'o3610, 15'o04400, 6'o10, 15'o14410, 1'b1, 1'b1, 15'o04401, 1'b0, 15'o00000},
    '{12'o4412, 15'o00005, 6'o21, 15'o20012, 1'b1, 1'b0, 15'o00006, 1'b0, 15'o00000},
    '{12'o5377, 15'o67600, 6'o43, 15'o47777, 1'b0, 1'b0, 15'o67601, 1'b1, 15'o37777},
    '{12'o4177, 15'o10000, 6'o65, 15'o60177, 1'b0, 1'b0, 15'o10001, 1'b1, 15'o50200},
    '{12'o4377, 15'o27777, 6'o01, 15'o07777, 1'b0, 1'b0, 15'o20000, 1'b1, 15'o10000},
    '{12'o6401, 15'o00000, 6'o77, 15'o00000, 1'b0, 1'b0, 15'o00001, 1'b0, 15'o00000},
    '{12'o7410, 15'o77777, 6'o77, 15'o00000, 1'b0, 1'b0, 15'o70000, 1'b0, 15'o00000},
    '{12'o3000, 15'o01234, 6'o77, 15'o70000, 1'b0, 1'b0, 15'o01235, 1'b0, 15'o00000}
  };

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  // {load,store,acc_rd,acc_wr,link_rd,link_wr,redirect,unsup}
  function automatic logic [7:0] model_flags(input logic [2:0] op);
    case (op)
      3'd0: return 8'b1011_0000;
      3'd1: return 8'b1011_1100;
      3'd2: return 8'b1100_0010;
      3'd3: return 8'b0111_0000;
      3'd4: return 8'b0100_0010;
      3'd5: return 8'b0000_0010;
      default: return 8'b0000_0001;
    endcase
  endfunction

  function automatic string flag_req(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R6";
      3'd2, 3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic apply(input logic [11:0] ins, input logic [14:0] pc, input logic [5:0] df);
    @(posedge clk);
    #0.5;
    instr_i = ins;
    pc_i    = pc;
    dfif_i  = df;
    @(negedge clk);
  endtask

  function automatic logic [7:0] act_flags();
    return {load_o, store_o, acc_rd_o, acc_wr_o, link_rd_o, link_wr_o, redirect_o, unsupported_o};
  endfunction

  initial begin
    instr_i = '0;
    pc_i    = '0;
    dfif_i  = '0;
    @(negedge clk);
    // all-zero inputs: direct logical AND at address 0
    chk("R6", "idle flags", 32'(act_flags()), 32'(8'b1011_0000));
    chk("R3", "idle addr", 32'(addr_o), 32'd0);
    chk("R2", "idle next pc", 32'(next_pc_o), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].instr, VECS[i].pc, VECS[i].dfif);
      chk("R1", "opcode", 32'(opcode_o), 32'(VECS[i].instr[11:9]));
      chk("R3", "addr", 32'(addr_o), 32'(VECS[i].addr));
      chk("R5", "indirect", 32'(indirect_o), 32'(VECS[i].ind));
      chk("R10", "autoinc", 32'(autoinc_o), 32'(VECS[i].ainc));
      chk("R2", "next pc", 32'(next_pc_o), 32'(VECS[i].npc));
      chk("R11", "tgt valid", 32'(jump_tgt_valid_o), 32'(VECS[i].tv));
      chk("R11", "tgt", 32'(jump_tgt_o), 32'(VECS[i].tgt));
      chk(flag_req(VECS[i].instr[11:9]), "flags", 32'(act_flags()),
          32'(model_flags(VECS[i].instr[11:9])));
    end

    // every opcode, direct and indirect, page bit set
    for (int op = 0; op < 8; op++) begin
      for (int ib = 0; ib < 2; ib++) begin
        logic [11:0] ins;
        ins = {3'(op), 1'(ib), 1'b1, 7'o055};
        apply(ins, 15'o25432, 6'o36);
        chk(flag_req(3'(op)), "sweep flags", 32'(act_flags()), 32'(model_flags(3'(op))));
        if (op < 6) begin
          chk("R4", "sweep dfield", 32'(addr_o), 32'(15'o35455));
          chk("R5", "sweep indirect", 32'(indirect_o), 32'(ib));
        end else begin
          chk("R9", "sweep addr", 32'(addr_o), 32'd0);
          chk("R9", "sweep indirect", 32'(indirect_o), 32'd0);
        end
      end
    end

    // autoincrement slot bits 6:3, with and without page bit, per opcode
    for (int op = 0; op < 8; op++) begin
      for (int s = 0; s < 16; s++) begin
        for (int pg = 0; pg < 2; pg++) begin
          logic exp_ai;
          exp_ai = (op == 0 || op == 1 || op == 3) && (s == 1);
          apply({3'(op), 1'b1, 1'(pg), 4'(s), 3'd5}, 15'o01600, 6'o00);
          chk("R10", "autoinc sweep", 32'(autoinc_o), 32'(exp_ai));
        end
      end
    end

    // direct current-page: bit 7 uses pc page
    for (int pg = 0; pg < 32; pg++) begin
      apply({3'd0, 1'b0, 1'b1, 7'o123}, {3'd2, 5'(pg), 7'o044}, 6'o00);
      chk("R3", "page select", 32'(addr_o), 32'({3'd0, 5'(pg), 7'o123}));
      apply({3'd0, 1'b0, 1'b0, 7'o123}, {3'd2, 5'(pg), 7'o044}, 6'o00);
      chk("R3", "page zero", 32'(addr_o), 32'(15'o00123));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule